// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block steers a processor core through the switch into an exception handler and back out again. It watches seven trap sources: reset, undefined instruction, software trap, instruction-fetch abort, data abort, normal interrupt and fast interrupt. When a source is pending, it picks the most urgent one and runs a two-cycle entry sequence.

In the first entry cycle it stores the live status word into the saved-status slot of the handling mode. In the same cycle it stores the return address into that mode's link slot. In the second cycle it writes a new status word and points the program counter at the trap's vector.

A return request runs a single cycle. That cycle copies the current mode's saved status back into the status word and the current mode's link value into the program counter.

The banked storage, the status register and the program counter stay outside the block. The block only drives their write strobes and data and reads back the two banked values of the current mode.

Top module: `trap_sequencer`

## Requirements
- R1: While `rst` is high, `busy` and every write strobe stay low. The first entry after reset is a reset trap. It lands in mode 5'h13, with status bits 7 (interrupt disable), 6 (fast-interrupt disable) and 5 (compact-instruction state) set to 1, 1 and 0. The program counter becomes base + 0.
- R2: When several sources are pending, the order from most to least urgent is: reset, data abort, fast interrupt, interrupt, fetch abort, undefined, software trap.
- R3: In the first entry cycle, `sav_we` is high and `bank_mode` carries the target mode. `sav_wdata` equals the status word as it was before entry, and no status bit has changed yet.
- R4: In that same cycle, `lnk_we` is high and `lnk_wdata` carries `ret_addr` into the target mode's link slot.
- R5: The status written in the second entry cycle works as follows:
  - Bits [4:0] hold the target mode: 5'h13 for reset and software trap, 5'h17 for either abort, 5'h1B for undefined, 5'h12 for interrupt and 5'h11 for fast interrupt.
  - Bit 7 is set and bit 5 is cleared.
  - Bit 6 is set for reset and fast interrupt and kept otherwise.
  - Bits [31:8] are kept.
- R6: The vector is base + 16 × slot. The slots are reset 0, undefined 1, software trap 2, fetch abort 3, data abort 4, interrupt 6 and fast interrupt 7. The base is 32'h0 with `hivec` low and 32'hFFFF0000 with `hivec` high.
- R7: A held `irq_lvl` is taken only while status bit 7 is clear. A held `fiq_lvl` is taken only while status bit 6 is clear.
- R8: `busy` is high for exactly two cycles per entry: the save cycle, then the switch cycle. Status and program counter writes happen in the switch cycle. At least one idle cycle follows each entry.
- R9: A `ret_req` seen while idle, with no trap pending, produces one cycle in which:
  - `bank_mode` is the current mode;
  - `st_wdata` is `sav_rd_data` and `pc_wdata` is `lnk_rd_data`;
  - both `st_we` and `pc_we` are high.
- R10: A synchronous trap pulse that arrives while another trap wins, or while `busy` is high, is held. It is taken after the current entry, in priority order.
- R11: A `ret_req` seen while `busy` is high, or in the same cycle that a trap is pending, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; arms a reset trap |
| hivec | input | 1 | Selects the high vector base |
| irq_lvl | input | 1 | Normal interrupt level |
| fiq_lvl | input | 1 | Fast interrupt level |
| undef_req | input | 1 | Undefined-instruction pulse |
| swi_req | input | 1 | Software-trap pulse |
| pabt_req | input | 1 | Fetch-abort pulse |
| dabt_req | input | 1 | Data-abort pulse |
| ret_req | input | 1 | Return-from-handler pulse |
| cur_status | input | XLEN | Live status word |
| ret_addr | input | XLEN | Return address to bank on entry |
| sav_rd_data | input | XLEN | Saved status of mode `bank_mode` |
| lnk_rd_data | input | XLEN | Link value of mode `bank_mode` |
| busy | output | 1 | High during the two entry cycles |
| bank_mode | output | 5 | Mode selecting the banked slot to write or read |
| sav_we | output | 1 | Saved-status write strobe |
| sav_wdata | output | XLEN | Saved-status write data |
| lnk_we | output | 1 | Link write strobe |
| lnk_wdata | output | XLEN | Link write data |
| st_we | output | 1 | Status write strobe |
| st_wdata | output | XLEN | New status word |
| pc_we | output | 1 | Program counter write strobe |
| pc_wdata | output | XLEN | New program counter |

## Verification
The assertions assume that the status register outside the block changes only through `st_we`. That keeps `cur_status` steady across the two entry cycles, so the value banked in the save cycle still matches the live word in the switch cycle. They also assume the banked read data follows `bank_mode` within the same cycle.

The bench keeps within these assumptions by modelling the status, program counter and both banks itself. The model updates only on the block's strobes, plus direct preloads made while the block is idle. Trap inputs change only at falling edges.

// File: rtl/trap_pkg.sv
`timescale 1ns/1ps
package trap_pkg;

    localparam int unsigned MODE_W = 5;
    localparam int unsigned BIT_T  = 5;
    localparam int unsigned BIT_F  = 6;
    localparam int unsigned BIT_I  = 7;
    localparam int unsigned NUM_EV = 7;

    // priority ranks, 0 is the most urgent
    localparam int unsigned RK_RST  = 0;
    localparam int unsigned RK_DABT = 1;
    localparam int unsigned RK_FIQ  = 2;
    localparam int unsigned RK_IRQ  = 3;
    localparam int unsigned RK_PABT = 4;
    localparam int unsigned RK_UND  = 5;
    localparam int unsigned RK_SWI  = 6;

    typedef enum logic [MODE_W-1:0] {
        MD_USR = 5'h10,
        MD_FIQ = 5'h11,
        MD_IRQ = 5'h12,
        MD_SVC = 5'h13,
        MD_ABT = 5'h17,
        MD_UND = 5'h1B,
        MD_SYS = 5'h1F
    } mode_e;

    typedef enum logic [2:0] {
        SL_RST  = 3'd0,
        SL_UND  = 3'd1,
        SL_SWI  = 3'd2,
        SL_PABT = 3'd3,
        SL_DABT = 3'd4,
        SL_IRQ  = 3'd6,
        SL_FIQ  = 3'd7
    } slot_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SAVE,
        ST_SWITCH,
        ST_RESTORE
    } seq_state_e;

    function automatic slot_e rank_to_slot(input int unsigned rk);
        case (rk)
            RK_RST:  return SL_RST;
            RK_DABT: return SL_DABT;
            RK_FIQ:  return SL_FIQ;
            RK_IRQ:  return SL_IRQ;
            RK_PABT: return SL_PABT;
            RK_UND:  return SL_UND;
            default: return SL_SWI;
        endcase
    endfunction

    function automatic mode_e slot_to_mode(input slot_e s);
        case (s)
            SL_RST, SL_SWI:   return MD_SVC;
            SL_PABT, SL_DABT: return MD_ABT;
            SL_UND:           return MD_UND;
            SL_IRQ:           return MD_IRQ;
            default:          return MD_FIQ;
        endcase
    endfunction

    function automatic logic slot_sets_f(input slot_e s);
        return (s == SL_RST) || (s == SL_FIQ);
    endfunction

endpackage

// File: rtl/trap_arbiter.sv
`timescale 1ns/1ps
module trap_arbiter #(
    parameter int unsigned N     = 7,
    parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     req,
    output logic [N-1:0]     grant,
    output logic [IDX_W-1:0] idx,
    output logic             any
);

    always_comb begin
        logic found;
        found = 1'b0;
        grant = '0;
        idx   = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !found) begin
                grant[i] = 1'b1;
                idx      = IDX_W'(i);
                found    = 1'b1;
            end
        end
    end

    assign any = |req;

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant)); // R2
    AST_GRANT_FROM_REQ: assert property (@(posedge clk) disable iff (rst)
        any |-> (|(grant & req))); // R2

endmodule

// File: rtl/trap_vector.sv
`timescale 1ns/1ps
module trap_vector
    import trap_pkg::*;
#(
    parameter int unsigned     XLEN       = 32,
    parameter logic [XLEN-1:0] LOW_BASE   = '0,
    parameter logic [XLEN-1:0] HIGH_BASE  = 32'hFFFF_0000,
    parameter int unsigned     SLOT_BYTES = 16
) (
    input  slot_e           slot,
    input  logic            hivec,
    input  logic [XLEN-1:0] cur_status,
    output mode_e           tgt_mode,
    output logic [XLEN-1:0] new_status,
    output logic [XLEN-1:0] vec_pc
);

    localparam int unsigned SLOT_SH = $clog2(SLOT_BYTES);

    always_comb begin
        tgt_mode   = slot_to_mode(slot);
        new_status = cur_status;
        new_status[MODE_W-1:0] = tgt_mode;
        new_status[BIT_T] = 1'b0;
        new_status[BIT_I] = 1'b1;
        if (slot_sets_f(slot)) begin
            new_status[BIT_F] = 1'b1;
        end
        vec_pc = (hivec ? HIGH_BASE : LOW_BASE) + (XLEN'(slot) << SLOT_SH);
    end

endmodule

// File: rtl/trap_sequencer.sv
`timescale 1ns/1ps
module trap_sequencer
    import trap_pkg::*;
#(
    parameter int unsigned     XLEN       = 32,
    parameter logic [XLEN-1:0] LOW_BASE   = '0,
    parameter logic [XLEN-1:0] HIGH_BASE  = 32'hFFFF_0000,
    parameter int unsigned     SLOT_BYTES = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            hivec,
    input  logic            irq_lvl,
    input  logic            fiq_lvl,
    input  logic            undef_req,
    input  logic            swi_req,
    input  logic            pabt_req,
    input  logic            dabt_req,
    input  logic            ret_req,
    input  logic [XLEN-1:0] cur_status,
    input  logic [XLEN-1:0] ret_addr,
    input  logic [XLEN-1:0] sav_rd_data,
    input  logic [XLEN-1:0] lnk_rd_data,
    output logic            busy,
    output logic [4:0]      bank_mode,
    output logic            sav_we,
    output logic [XLEN-1:0] sav_wdata,
    output logic            lnk_we,
    output logic [XLEN-1:0] lnk_wdata,
    output logic            st_we,
    output logic [XLEN-1:0] st_wdata,
    output logic            pc_we,
    output logic [XLEN-1:0] pc_wdata
);

    localparam int unsigned    N    = NUM_EV;
    localparam int unsigned    RK_W = $clog2(N);
    localparam logic [N-1:0]   LATCHED = ~((N'(1) << RK_IRQ) | (N'(1) << RK_FIQ));
    localparam logic [N-1:0]   RST_PEND = N'(1) << RK_RST;

    seq_state_e      state_q, state_d;
    logic [N-1:0]    pend_q, pend_d, sync_in, live, grant;
    logic [RK_W-1:0] win_idx;
    logic            any_live, take;
    slot_e           sel_q;
    mode_e           tgt_mode;
    logic [XLEN-1:0] entry_status, vec_pc;

    always_comb begin
        sync_in          = '0;
        sync_in[RK_DABT] = dabt_req;
        sync_in[RK_PABT] = pabt_req;
        sync_in[RK_UND]  = undef_req;
        sync_in[RK_SWI]  = swi_req;
        live             = pend_q | sync_in;
        live[RK_IRQ]     = irq_lvl & ~cur_status[BIT_I];
        live[RK_FIQ]     = fiq_lvl & ~cur_status[BIT_F];
    end

    trap_arbiter #(.N(N), .IDX_W(RK_W)) u_arb (
        .clk   (clk),
        .rst   (rst),
        .req   (live),
        .grant (grant),
        .idx   (win_idx),
        .any   (any_live)
    );

    assign take   = (state_q == ST_IDLE) && any_live;
    assign pend_d = (pend_q | sync_in) & LATCHED & ~(take ? grant : '0);

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: begin
                if (take) begin
                    state_d = ST_SAVE;
                end else if (ret_req) begin
                    state_d = ST_RESTORE;
                end
            end
            ST_SAVE:   state_d = ST_SWITCH;
            ST_SWITCH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pend_q  <= RST_PEND;
            sel_q   <= SL_RST;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
            if (take) begin
                sel_q <= rank_to_slot(int'(win_idx));
            end
        end
    end

    trap_vector #(
        .XLEN       (XLEN),
        .LOW_BASE   (LOW_BASE),
        .HIGH_BASE  (HIGH_BASE),
        .SLOT_BYTES (SLOT_BYTES)
    ) u_vec (
        .slot       (sel_q),
        .hivec      (hivec),
        .cur_status (cur_status),
        .tgt_mode   (tgt_mode),
        .new_status (entry_status),
        .vec_pc     (vec_pc)
    );

    always_comb begin
        busy      = (state_q == ST_SAVE) || (state_q == ST_SWITCH);
        sav_we    = (state_q == ST_SAVE);
        lnk_we    = (state_q == ST_SAVE);
        sav_wdata = cur_status;
        lnk_wdata = ret_addr;
        bank_mode = (state_q == ST_RESTORE) ? cur_status[MODE_W-1:0] : tgt_mode;
        st_we     = (state_q == ST_SWITCH) || (state_q == ST_RESTORE);
        pc_we     = st_we;
        st_wdata  = (state_q == ST_RESTORE) ? sav_rd_data : entry_status;
        pc_wdata  = (state_q == ST_RESTORE) ? lnk_rd_data : vec_pc;
    end

    AST_SAVE_THEN_SWITCH: assert property (@(posedge clk) disable iff (rst)
        sav_we |=> (busy && st_we && pc_we && !sav_we)); // R8
    AST_BUSY_ENDS_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(st_we)); // R8
    AST_SAVED_MATCHES_LIVE: assert property (@(posedge clk) disable iff (rst)
        (busy && st_we) |-> ($past(sav_we) && $past(sav_wdata) == cur_status
                             && $past(bank_mode) == bank_mode)); // R3
    AST_ENTRY_MASKS_IRQ: assert property (@(posedge clk) disable iff (rst)
        (busy && st_we) |-> (st_wdata[BIT_I] && !st_wdata[BIT_T]
                             && st_wdata[MODE_W-1:0] == bank_mode)); // R5
    AST_VECTOR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        (busy && pc_we) |-> (pc_wdata[3:0] == 4'h0)); // R6
    AST_RESTORE_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
        (st_we && !busy) |-> !$past(busy)); // R11
    AST_QUIET_IN_RESET: assert property (@(posedge clk)
        rst |=> (!busy && !st_we)); // R1

endmodule

// File: tb/trap_sequencer_bench.sv
`timescale 1ns/1ps
module trap_sequencer_bench;
    import trap_pkg::*;

    logic clk = 1'b0;
    logic rst, hivec, irq_lvl, fiq_lvl, undef_req, swi_req, pabt_req, dabt_req, ret_req;
    logic [31:0] cur_status, ret_addr, sav_rd_data, lnk_rd_data;
    logic        busy, sav_we, lnk_we, st_we, pc_we;
    logic [4:0]  bank_mode;
    logic [31:0] sav_wdata, lnk_wdata, st_wdata, pc_wdata;

    logic [31:0] st_m, pc_m;
    logic [31:0] sav_bank [32];
    logic [31:0] lnk_bank [32];

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    trap_sequencer u_trap_sequencer (
        .clk(clk), .rst(rst), .hivec(hivec), .irq_lvl(irq_lvl), .fiq_lvl(fiq_lvl),
        .undef_req(undef_req), .swi_req(swi_req), .pabt_req(pabt_req), .dabt_req(dabt_req),
        .ret_req(ret_req), .cur_status(cur_status), .ret_addr(ret_addr),
        .sav_rd_data(sav_rd_data), .lnk_rd_data(lnk_rd_data), .busy(busy),
        .bank_mode(bank_mode), .sav_we(sav_we), .sav_wdata(sav_wdata), .lnk_we(lnk_we),
        .lnk_wdata(lnk_wdata), .st_we(st_we), .st_wdata(st_wdata), .pc_we(pc_we),
        .pc_wdata(pc_wdata)
    );

    // core-side storage model
    always @(posedge clk) begin
        if (sav_we) sav_bank[bank_mode] <= sav_wdata;
        if (lnk_we) lnk_bank[bank_mode] <= lnk_wdata;
        if (st_we)  st_m <= st_wdata;
        if (pc_we)  pc_m <= pc_wdata;
    end

    assign cur_status  = st_m;
    assign sav_rd_data = sav_bank[bank_mode];
    assign lnk_rd_data = lnk_bank[bank_mode];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    // call at a falling edge where the next rising edge starts the save cycle
    task automatic expect_entry(input mode_e md, input slot_e sl, input logic fset,
                                input logic hv, input logic ret_mid);
        logic [31:0] pre_st, pre_pc, exp_pc, exp_st;
        pre_st = st_m;
        pre_pc = ret_addr;
        exp_pc = (hv ? 32'hFFFF_0000 : 32'h0) + (32'(sl) << 4);
        exp_st = {pre_st[31:8], 1'b1, pre_st[6] | fset, 1'b0, md};
        @(negedge clk);
        undef_req = 0; swi_req = 0; pabt_req = 0; dabt_req = 0;
        ret_req = ret_mid;
        chk("R8 busy in save cycle", 32'(busy), 32'd1);
        chk("R3 saved-status strobe", 32'(sav_we), 32'd1);
        chk("R3 bank mode", 32'(bank_mode), 32'(md));
        chk("R3 saved value is pre-entry status", sav_wdata, pre_st);
        chk("R4 link strobe", 32'(lnk_we), 32'd1);
        chk("R4 link value", lnk_wdata, pre_pc);
        @(negedge clk);
        ret_req = 0;
        chk("R8 busy in switch cycle", 32'(busy), 32'd1);
        chk("R8 status strobe in switch", 32'(st_we), 32'd1);
        chk("R6 vector address", pc_wdata, exp_pc);
        @(negedge clk);
        chk("R8 busy drops after two cycles", 32'(busy), 32'd0);
        chk("R5 new status word", st_m, exp_st);
        chk("R6 pc loaded", pc_m, exp_pc);
        chk("R3 banked saved status", sav_bank[md], pre_st);
        chk("R4 banked link", lnk_bank[md], pre_pc);
    endtask

    task automatic t_reset();
        rst = 1; st_m = 32'h0000_0010; pc_m = 32'h0;
        repeat (3) @(negedge clk);
        chk("R1 busy low in reset", 32'(busy), 32'd0);
        chk("R1 no status write in reset", 32'(st_we), 32'd0);
        ret_addr = 32'h0000_0100;
        rst = 0;
        expect_entry(MD_SVC, SL_RST, 1'b1, 1'b0, 1'b0);
        chk("R1 reset mode", 32'(st_m[4:0]), 32'h13);
        chk("R1 reset masks", 32'(st_m[7:5]), 32'b110);
    endtask

    task automatic t_sync_each();
        st_m = 32'hA000_0010; ret_addr = 32'h0000_2004; undef_req = 1;
        expect_entry(MD_UND, SL_UND, 1'b0, 1'b0, 1'b0);
        st_m = 32'h4000_0030; ret_addr = 32'h0000_3008; swi_req = 1;
        expect_entry(MD_SVC, SL_SWI, 1'b0, 1'b0, 1'b0);
        st_m = 32'h2000_0010; ret_addr = 32'h0000_400C; pabt_req = 1;
        expect_entry(MD_ABT, SL_PABT, 1'b0, 1'b0, 1'b0);
        st_m = 32'h1000_0050; ret_addr = 32'h0000_5010; dabt_req = 1;
        expect_entry(MD_ABT, SL_DABT, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_masking();
        st_m = 32'h0000_00D0; irq_lvl = 1; fiq_lvl = 1;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk("R7 masked interrupts not taken", 32'(busy), 32'd0);
        end
        chk("R7 status untouched while masked", st_m, 32'h0000_00D0);
        irq_lvl = 0; fiq_lvl = 0;
        @(negedge clk);
        st_m = 32'h0000_0050; ret_addr = 32'h0000_6000; irq_lvl = 1;
        expect_entry(MD_IRQ, SL_IRQ, 1'b0, 1'b0, 1'b0);
        irq_lvl = 0;
        st_m = 32'h0000_0090; ret_addr = 32'h0000_7000; fiq_lvl = 1;
        expect_entry(MD_FIQ, SL_FIQ, 1'b1, 1'b0, 1'b0);
        fiq_lvl = 0;
    endtask

    task automatic t_priority();
        st_m = 32'h0000_0010; ret_addr = 32'h0000_8000;
        dabt_req = 1; pabt_req = 1; undef_req = 1; swi_req = 1; irq_lvl = 1; fiq_lvl = 1;
        expect_entry(MD_ABT, SL_DABT, 1'b0, 1'b0, 1'b0);   // R2 most urgent
        expect_entry(MD_FIQ, SL_FIQ, 1'b1, 1'b0, 1'b0);    // R2 R10
        irq_lvl = 0; fiq_lvl = 0;
        expect_entry(MD_ABT, SL_PABT, 1'b0, 1'b0, 1'b0);   // R10 held pulse
        expect_entry(MD_UND, SL_UND, 1'b0, 1'b0, 1'b0);    // R10
        expect_entry(MD_SVC, SL_SWI, 1'b0, 1'b0, 1'b0);    // R10
        @(negedge clk);
        chk("R10 nothing left pending", 32'(busy), 32'd0);
    endtask

    task automatic t_hivec();
        hivec = 1; st_m = 32'h0000_0010; ret_addr = 32'h0000_9000; swi_req = 1;
        expect_entry(MD_SVC, SL_SWI, 1'b0, 1'b1, 1'b0);
        hivec = 0;
    endtask

    task automatic t_return();
        st_m = 32'h0000_00D7;
        sav_bank[5'h17] = 32'h6000_0010;
        lnk_bank[5'h17] = 32'h0000_1234;
        ret_req = 1;
        @(negedge clk);
        ret_req = 0;
        chk("R9 restore strobe", 32'({st_we, pc_we, busy}), 32'b110);
        chk("R9 reads current mode bank", 32'(bank_mode), 32'h17);
        @(negedge clk);
        chk("R9 status restored", st_m, 32'h6000_0010);
        chk("R9 pc restored", pc_m, 32'h0000_1234);
    endtask

    task automatic t_ret_ignored();
        logic [31:0] held;
        st_m = 32'h0000_0010; ret_addr = 32'h0000_A000; swi_req = 1;
        expect_entry(MD_SVC, SL_SWI, 1'b0, 1'b0, 1'b1);
        held = st_m;
        @(negedge clk);
        chk("R11 return while busy ignored", st_m, held);
        st_m = 32'h0000_0010; ret_addr = 32'h0000_B000; undef_req = 1; ret_req = 1;
        expect_entry(MD_UND, SL_UND, 1'b0, 1'b0, 1'b0);
        held = st_m;
        @(negedge clk);
        chk("R11 return with trap pending ignored", st_m, held);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        hivec = 0; irq_lvl = 0; fiq_lvl = 0; undef_req = 0; swi_req = 0;
        pabt_req = 0; dabt_req = 0; ret_req = 0; ret_addr = 32'h0;
        t_reset();
        t_sync_each();
        t_masking();
        t_priority();
        t_hivec();
        t_return();
        t_ret_ignored();
        repeat (2) @(negedge clk);
        summary();
    end

endmodule